// File: doc/BRIEF.md
# Pulsed Wetting Current Controller

This block sets the current code sent to an external load DAC that sinks a wetting current from a binary input line. Dissipating a burst of current on the line clears contact films and swamps high-voltage noise. The block takes ADC samples of the line voltage, an enable word, a mode bit, a thermal-protection inhibit from an energy meter, and the programmed codes and durations. From these it produces the current code and a pulse-active flag that the energy meter uses to accumulate dissipated energy.

The block has two modes. In threshold-idle mode (mode bit 0, the reset default), the line idles at the low current code. When a sample rises above a programmable rise threshold, the block applies the high code for a programmed number of 10 µs step ticks, then returns to the low code. Only one pulse is produced per rising crossing. In high-idle mode (mode bit 1), the high code is applied continuously and the rise threshold plays no part. Whenever the inhibit is asserted, the block drops to the low code at once and starts no new pulse.

Top module: `wet_pulse_ctrl`

## Requirements
- R1: After reset, and whenever the enable word is not 0xC000, the current code is 0 and pulse_active is 0.
- R2: The block is enabled only when the enable word equals exactly 0xC000; any other value, such as 0xC001 or 0x8000, leaves it off.
- R3: In mode 0, enabled and not inhibited, a valid sample with adc_code strictly greater than rise_thr, while the trigger is armed, starts a pulse. From the next cycle the current code is high_code and pulse_active is 1.
- R4: The high phase ends on the clock edge of the high_time-th step tick counted after the pulse started, and the low code follows. If high_time is 0, no pulse starts.
- R5: The trigger is armed after reset and by any valid sample with adc_code <= rise_thr. Any valid sample above rise_thr disarms it, so samples that stay above the threshold, or a crossing that happens during a pulse, start no further pulse.
- R6: While inhibit is 1 and the block is enabled, the current code is low_code and pulse_active is 0 in the same cycle. A pulse in progress is cancelled, and a crossing seen during the inhibit starts no pulse.
- R7: In mode 1, enabled and not inhibited, the current code is high_code and pulse_active is 1 regardless of adc_code and rise_thr.
- R8: In mode 0, enabled, with no pulse in progress, the current code is low_code and pulse_active is 0.
- R9: Switching to mode 1 or disabling the block cancels a mode-0 pulse. Returning to mode 0 then gives the low code until a new crossing occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_word | input | 16 | Enable register value; 0xC000 turns the block on |
| mode_high_idle | input | 1 | 0: threshold-triggered pulses, 1: high code while idle |
| inhibit | input | 1 | Thermal-protection inhibit from the energy meter |
| step_tick | input | 1 | One-cycle strobe every 10 µs |
| sample_valid | input | 1 | adc_code carries a new sample |
| adc_code | input | 8 | Line voltage sample |
| rise_thr | input | 8 | Rise threshold for mode 0 |
| high_code | input | 8 | Current code during the high phase |
| low_code | input | 8 | Steady current code |
| high_time | input | 16 | High phase length in step ticks |
| cur_code | output | 8 | Current code to the load DAC |
| pulse_active | output | 1 | High current is being applied |

## Verification
The bench targets four cases. The first is a sample exactly equal to the threshold: a design that used >= would fire a pulse there. The second is input that stays above the threshold: a design that retriggered on level would repeat pulses without end. The third is the exact tick on which the high phase ends, where an off-by-one shows up as one tick too many or too few. The fourth is an inhibit raised during a pulse and released while the line is still high: a design that latched the pending pulse would resume the high current when it should stay low. Enable words one bit away from the key and a zero high time are also driven, because a loose decode or a zero-length pulse would appear at the outputs.

// File: rtl/wet_pkg.sv
package wet_pkg;
  typedef enum logic {
    MODE_THRESHOLD = 1'b0,
    MODE_HIGH_IDLE = 1'b1
  } wet_mode_e;
endpackage

// File: rtl/wet_trigger.sv
module wet_trigger #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] rise_thr,
  input  logic              allow,
  output logic              start,
  output logic              armed
);
  function automatic logic above_thr(input logic [CODE_W-1:0] code,
                                     input logic [CODE_W-1:0] thr);
    return code > thr;
  endfunction

  logic sample_above;
  assign sample_above = sample_valid && above_thr(adc_code, rise_thr);
  assign start        = allow && sample_above && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b1;
    else if (sample_valid) armed <= !above_thr(adc_code, rise_thr);
  end

  // one edge gives one pulse: a start always leaves the trigger disarmed
  assert_disarm_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !armed);
endmodule

// File: rtl/wet_timer.sv
module wet_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic              step_tick,
  input  logic [TIME_W-1:0] high_time,
  output logic              in_pulse
);
  localparam int CNT_W = TIME_W + 1;

  logic [CNT_W-1:0] ticks_done;

  function automatic logic phase_over(input logic [CNT_W-1:0] done,
                                      input logic [TIME_W-1:0] limit);
    return (done + 1'b1) >= {1'b0, limit};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse   <= 1'b0;
      ticks_done <= '0;
    end else if (cancel) begin
      in_pulse   <= 1'b0;
    end else if (in_pulse) begin
      if (step_tick) begin
        ticks_done <= ticks_done + 1'b1;
        if (phase_over(ticks_done, high_time)) in_pulse <= 1'b0;
      end
    end else if (start) begin
      in_pulse   <= 1'b1;
      ticks_done <= '0;
    end
  end

  // cancel always wins over an ongoing or starting pulse
  assert_cancel_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !in_pulse);
endmodule

// File: rtl/wet_code_sel.sv
module wet_code_sel #(
  parameter int CODE_W = 8
) (
  input  logic              enabled,
  input  logic              high_idle,
  input  logic              inhibit,
  input  logic              in_pulse,
  input  logic [CODE_W-1:0] high_code,
  input  logic [CODE_W-1:0] low_code,
  output logic [CODE_W-1:0] cur_code,
  output logic              pulse_active
);
  logic want_high;
  assign want_high = high_idle || in_pulse;

  always_comb begin
    cur_code     = '0;
    pulse_active = 1'b0;
    if (enabled) begin
      if (want_high && !inhibit) begin
        cur_code     = high_code;
        pulse_active = 1'b1;
      end else begin
        cur_code = low_code;
      end
    end
  end
endmodule

// File: rtl/wet_pulse_ctrl.sv
module wet_pulse_ctrl #(
  parameter int          CODE_W     = 8,
  parameter int          TIME_W     = 16,
  parameter int          KEY_W      = 16,
  parameter logic [15:0] ENABLE_KEY = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  enable_word,
  input  logic              mode_high_idle,
  input  logic              inhibit,
  input  logic              step_tick,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] rise_thr,
  input  logic [CODE_W-1:0] high_code,
  input  logic [CODE_W-1:0] low_code,
  input  logic [TIME_W-1:0] high_time,
  output logic [CODE_W-1:0] cur_code,
  output logic              pulse_active
);
  import wet_pkg::*;

  localparam logic [KEY_W-1:0] KEY = KEY_W'(ENABLE_KEY);

  wet_mode_e mode;
  logic enabled, cancel, allow, start, armed, in_pulse;

  assign mode    = wet_mode_e'(mode_high_idle);
  assign enabled = (enable_word == KEY);
  assign cancel  = !enabled || (mode == MODE_HIGH_IDLE) || inhibit;
  assign allow   = !cancel && !in_pulse && (high_time != '0);

  wet_trigger #(.CODE_W(CODE_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .adc_code(adc_code), .rise_thr(rise_thr), .allow(allow),
    .start(start), .armed(armed)
  );

  wet_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .step_tick(step_tick), .high_time(high_time), .in_pulse(in_pulse)
  );

  wet_code_sel #(.CODE_W(CODE_W)) u_sel (
    .enabled(enabled), .high_idle(mode == MODE_HIGH_IDLE), .inhibit(inhibit),
    .in_pulse(in_pulse), .high_code(high_code), .low_code(low_code),
    .cur_code(cur_code), .pulse_active(pulse_active)
  );

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (cur_code == '0) && !pulse_active);

  assert_start_gives_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> in_pulse);

  assert_inhibit_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && inhibit) |-> (cur_code == low_code) && !pulse_active);

  assert_high_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && mode_high_idle && !inhibit) |-> (cur_code == high_code) && pulse_active);

  assert_mode_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled || mode_high_idle) |=> !in_pulse);
endmodule

// File: tb/tb_wet_pulse_ctrl.sv
module tb_wet_pulse_ctrl;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] enable_word = '0;
  logic mode_high_idle = 1'b0, inhibit = 1'b0, step_tick = 1'b0, sample_valid = 1'b0;
  logic [7:0] adc_code = '0, rise_thr = 8'h1E, high_code = 8'h50, low_code = 8'h1E;
  logic [15:0] high_time = 16'd3;
  logic [7:0] cur_code;
  logic pulse_active;

  int checks = 0, fails = 0;
  bit m_armed = 1'b1, m_pulse = 1'b0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wet_pulse_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enable_word(enable_word), .mode_high_idle(mode_high_idle),
    .inhibit(inhibit), .step_tick(step_tick), .sample_valid(sample_valid),
    .adc_code(adc_code), .rise_thr(rise_thr), .high_code(high_code),
    .low_code(low_code), .high_time(high_time), .cur_code(cur_code),
    .pulse_active(pulse_active)
  );

  function automatic bit on_now();
    return enable_word == 16'hC000;
  endfunction

  function automatic logic [7:0] exp_code();
    if (!on_now()) return 8'h00;
    if (!inhibit && (mode_high_idle || m_pulse)) return high_code;
    return low_code;
  endfunction

  function automatic bit exp_active();
    return on_now() && !inhibit && (mode_high_idle || m_pulse);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (cur_code !== exp_code() || pulse_active !== exp_active()) begin
      fails++;
      $display("FAIL %s: code=%h active=%b expected code=%h active=%b",
               tag, cur_code, pulse_active, exp_code(), exp_active());
    end
  endtask

  task automatic advance_model();
    bit cut, go;
    cut = !on_now() || mode_high_idle || inhibit;
    go = !cut && !m_pulse && high_time != 0 && sample_valid && adc_code > rise_thr && m_armed;
    if (cut) m_pulse = 1'b0;
    else if (m_pulse) begin
      if (step_tick) begin
        m_cnt++;
        if (m_cnt >= int'(high_time)) m_pulse = 1'b0;
      end
    end else if (go) begin
      m_pulse = 1'b1;
      m_cnt = 0;
    end
    if (sample_valid) m_armed = !(adc_code > rise_thr);
  endtask

  // inputs are set by the caller before this; it samples after settling
  task automatic cyc(input string tag);
    #1;
    check(tag);
    advance_model();
    @(negedge clk);
  endtask

  task automatic sample(input logic [7:0] v, input bit tk, input string tag);
    sample_valid = 1'b1; adc_code = v; step_tick = tk;
    cyc(tag);
    sample_valid = 1'b0; step_tick = 1'b0;
  endtask

  function automatic string auto_tag();
    if (!on_now()) return "R1";
    if (inhibit) return "R6";
    if (mode_high_idle) return "R7";
    if (m_pulse) return "R4";
    return "R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    cyc("R1");
    rst_n = 1'b1;
    // disabled: crossings give nothing
    sample(8'h10, 1'b0, "R1");
    sample(8'h90, 1'b0, "R1");
    cyc("R1");
    // near-miss keys
    enable_word = 16'hC001; sample(8'h10, 1'b0, "R2"); sample(8'h90, 1'b0, "R2");
    enable_word = 16'h8000; cyc("R2");
    // enable, threshold mode, equal sample must not fire
    enable_word = 16'hC000;
    sample(8'h10, 1'b0, "R8");
    sample(8'h1E, 1'b0, "R3");
    cyc("R3");
    sample(8'h1F, 1'b0, "R3");
    cyc("R3");
    for (int i = 0; i < 3; i++) begin step_tick = 1'b1; cyc("R4"); step_tick = 1'b0; cyc("R4"); end
    cyc("R8");
    // staying high: no retrigger
    for (int i = 0; i < 4; i++) sample(8'hC0, 1'b1, "R5");
    // inhibit mid-pulse, release while high
    sample(8'h05, 1'b0, "R5");
    high_time = 16'd20;
    sample(8'hC0, 1'b0, "R3");
    cyc("R3");
    inhibit = 1'b1; cyc("R6"); sample(8'h05, 1'b0, "R6"); sample(8'hC0, 1'b0, "R6");
    inhibit = 1'b0; cyc("R6"); sample(8'hC0, 1'b0, "R6");
    // zero high time
    sample(8'h05, 1'b0, "R4"); high_time = 16'd0; sample(8'hC0, 1'b1, "R4"); cyc("R4");
    // high idle, threshold ignored; then mode cancel
    high_time = 16'd10;
    mode_high_idle = 1'b1; sample(8'h00, 1'b0, "R7"); sample(8'hFF, 1'b0, "R7");
    mode_high_idle = 1'b0; sample(8'h05, 1'b0, "R9"); sample(8'hC0, 1'b0, "R9"); cyc("R9");
    mode_high_idle = 1'b1; cyc("R9"); mode_high_idle = 1'b0; cyc("R9"); cyc("R9");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 3) enable_word = ($urandom_range(0, 3) == 0) ? 16'(($urandom())) : 16'hC000;
      if ($urandom_range(0, 99) < 2) mode_high_idle = ~mode_high_idle;
      if ($urandom_range(0, 99) < 4) inhibit = ~inhibit;
      if ($urandom_range(0, 99) < 2) high_time = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 99) < 2) rise_thr = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 99) < 2) begin high_code = 8'($urandom()); low_code = 8'($urandom()); end
      step_tick = ($urandom_range(0, 3) == 0);
      sample_valid = ($urandom_range(0, 2) == 0);
      adc_code = ($urandom_range(0, 1) == 0) ? rise_thr + 8'($urandom_range(0, 2)) - 8'd1
                                             : 8'($urandom());
      cyc(auto_tag());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule